// File: doc/BRIEF.md
# Endian-Selectable Bus-Matching Read Unpacker

This block sits between the read side of a 36-bit FIFO and a read port that may be narrower than the FIFO. It takes one long word at a time from the FIFO and hands it out as four 9-bit bytes, as two 18-bit halves, or as the whole 36-bit word. A static two-bit width input sets the port size. A byte-order setting is taken from a dual-purpose pin while reset is held. It sets whether the high or the low end of each long word leaves first. Once reset is released, the pin is free for other uses.

The FIFO side is a valid/ready handshake. A long word moves when `lw_valid` and `lw_ready` are both high at a clock edge. `lw_ready` stays low while a held word still has slices to deliver, so the FIFO keeps its data until the port has room. In the cycle that reads the last slice, `lw_ready` rises, so the next word loads without a gap. The port side has no back-pressure of its own. `rd_valid` marks that `rd_data` holds a slice, and a slice is consumed when `rd_en` is high at a clock edge while `rd_valid` is high.

Top module: `bm_read_unpacker`

## Requirements
- R1: While and right after reset, `rd_valid` is 0 and `lw_ready` is 1, and the first slice delivered after reset is the first slice of the first long word.
- R2: The byte order is the value of `order_pin` at the last clock edge while `rst_n` is low (1 = big-endian, 0 = little-endian); changing `order_pin` after reset has no effect on the delivered order until the next reset.
- R3: In byte mode (`port_width` = 2'b10) with big-endian order, four reads deliver bits [35:27], [26:18], [17:9] and then [8:0].
- R4: In byte mode with little-endian order, four reads deliver bits [8:0], [17:9], [26:18] and then [35:27].
- R5: In word mode (`port_width` = 2'b01) two reads deliver 18-bit halves: [35:18] first when big-endian, [17:0] first when little-endian.
- R6: In long-word mode (`port_width` = 2'b00, with 2'b11 treated the same) each read delivers the whole 36-bit word, and the byte order has no effect.
- R7: In byte and word modes, the bits of `rd_data` above the slice width are 0.
- R8: While a long word is held and the current cycle does not read its last slice, `lw_ready` is 0.
- R9: `rd_en` asserted while `rd_valid` is 0 is ignored and does not advance the slice position.
- R10: While `rd_valid` is 1 and `rd_en` is 0, `rd_valid` and `rd_data` hold their values into the next cycle.
- R11: A read of the last slice and the load of the next long word can happen in the same cycle, so a port reading every cycle gets one slice per cycle with no gap between long words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; order is captured while low |
| order_pin | input | 1 | Byte-order select, sampled during reset (1 big, 0 little) |
| port_width | input | 2 | Static port size: 00 long word, 01 word, 10 byte |
| lw_valid | input | 1 | FIFO offers a long word |
| lw_ready | output | 1 | Block accepts a long word this cycle |
| lw_data | input | 36 | Long word from the FIFO |
| rd_en | input | 1 | Read strobe from the port |
| rd_valid | output | 1 | `rd_data` carries a slice |
| rd_data | output | 36 | Current slice, zero-extended in narrow modes |

## Verification
Each port width is run under both captured orders with long words whose lanes all carry different values. Any swap, reversal or misplaced lane therefore shows up as a data mismatch against the scoreboard. The port is read in three ways. Reading every cycle shows that a new word loads in the same cycle as the last slice is read. Reading every other cycle shows that slices hold across stalls. A fully stopped port shows that `lw_ready` is withheld and that the first slice is presented before any read. Runs with the order pin toggled after reset, and with strobes on an empty port, separate a captured order from a live one and show that idle reads do not move the slice position.

// File: rtl/bm_unpack_pkg.sv
package bm_unpack_pkg;
  localparam int LW_W   = 36;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    PW_LONG = 2'b00,
    PW_WORD = 2'b01,
    PW_BYTE = 2'b10,
    PW_RSVD = 2'b11
  } port_width_e;
endpackage

// File: rtl/bm_hold_reg.sv
module bm_hold_reg #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         drop,
  input  logic [W-1:0] din,
  output logic [W-1:0] word_q,
  output logic         valid_q
);
  // load wins over drop: a refill in the cycle of the last read keeps valid high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      if (load) begin
        valid_q <= 1'b1;
        word_q  <= din;
      end else if (drop) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bm_slice_ctrl.sv
module bm_slice_ctrl
  import bm_unpack_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int CNT_W  = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       port_width,
  input  logic             rd_fire,
  output logic [CNT_W-1:0] idx_q,
  output logic             is_last
);
  int nslices;

  always_comb begin
    unique case (port_width_e'(port_width))
      PW_BYTE: nslices = NLANES;
      PW_WORD: nslices = NLANES / 2;
      default: nslices = 1;
    endcase
    is_last = (int'(idx_q) == nslices - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (rd_fire) begin
      if (is_last) idx_q <= '0;
      else         idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/bm_lane_mux.sv
module bm_lane_mux
  import bm_unpack_pkg::*;
#(
  parameter int LW_W   = 36,
  parameter int LANE_W = 9,
  parameter int NLANES = LW_W / LANE_W,
  parameter int NPAIRS = NLANES / 2,
  parameter int CNT_W  = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic [LW_W-1:0]  word,
  input  logic [1:0]       port_width,
  input  logic [CNT_W-1:0] idx,
  input  logic             big,
  output logic [LW_W-1:0]  slice
);
  logic [LANE_W-1:0]   lanes [NLANES];
  logic [2*LANE_W-1:0] pairs [NPAIRS];

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign lanes[g] = word[g*LANE_W +: LANE_W];
  end
  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    assign pairs[p] = word[p*2*LANE_W +: 2*LANE_W];
  end

  int byte_sel;
  int pair_sel;
  logic [LANE_W-1:0]   byte_pick;
  logic [2*LANE_W-1:0] pair_pick;

  always_comb begin
    // big-endian walks from the top lane down, little-endian from lane 0 up
    byte_sel  = big ? (NLANES - 1 - int'(idx)) : int'(idx);
    pair_sel  = big ? (NPAIRS - 1 - int'(idx)) : int'(idx);
    byte_pick = '0;
    pair_pick = '0;
    for (int k = 0; k < NLANES; k++)
      if (k == byte_sel) byte_pick = lanes[k];
    for (int k = 0; k < NPAIRS; k++)
      if (k == pair_sel) pair_pick = pairs[k];

    unique case (port_width_e'(port_width))
      PW_BYTE: slice = LW_W'(byte_pick);
      PW_WORD: slice = LW_W'(pair_pick);
      default: slice = word;
    endcase
  end
endmodule

// File: rtl/bm_read_unpacker.sv
module bm_read_unpacker
  import bm_unpack_pkg::*;
#(
  parameter int LW_W   = bm_unpack_pkg::LW_W,
  parameter int LANE_W = bm_unpack_pkg::LANE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            order_pin,
  input  logic [1:0]      port_width,
  input  logic            lw_valid,
  output logic            lw_ready,
  input  logic [LW_W-1:0] lw_data,
  input  logic            rd_en,
  output logic            rd_valid,
  output logic [LW_W-1:0] rd_data
);
  localparam int NLANES = LW_W / LANE_W;
  localparam int NPAIRS = NLANES / 2;
  localparam int CNT_W  = (NLANES > 1) ? $clog2(NLANES) : 1;

  logic             order_big_q;
  logic [LW_W-1:0]  held_word;
  logic             held_v;
  logic [CNT_W-1:0] slice_idx;
  logic             last_slice;
  logic             rd_fire;
  logic             lw_load;

  // order follows the pin while reset is low, then freezes
  always_ff @(posedge clk) begin
    if (!rst_n) order_big_q <= order_pin;
  end

  assign rd_fire  = rd_en && held_v;
  assign lw_ready = !held_v || (rd_en && last_slice);
  assign lw_load  = lw_valid && lw_ready;
  assign rd_valid = held_v;

  bm_hold_reg #(.W(LW_W)) hold_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (lw_load),
    .drop    (rd_fire && last_slice),
    .din     (lw_data),
    .word_q  (held_word),
    .valid_q (held_v)
  );

  bm_slice_ctrl #(.NLANES(NLANES), .CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_width (port_width),
    .rd_fire    (rd_fire),
    .idx_q      (slice_idx),
    .is_last    (last_slice)
  );

  bm_lane_mux #(
    .LW_W(LW_W), .LANE_W(LANE_W), .NLANES(NLANES), .NPAIRS(NPAIRS), .CNT_W(CNT_W)
  ) mux_i (
    .word       (held_word),
    .port_width (port_width),
    .idx        (slice_idx),
    .big        (order_big_q),
    .slice      (rd_data)
  );
endmodule

// File: rtl/bm_unpack_checker.sv
module bm_unpack_checker #(
  parameter int LW_W   = 36,
  parameter int LANE_W = 9,
  parameter int CNT_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       port_width,
  input logic             lw_ready,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [LW_W-1:0]  rd_data,
  input logic [CNT_W-1:0] slice_idx,
  input logic             order_q
);
  assert_idle_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> slice_idx == '0);

  assert_order_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(order_q));

  assert_long_unsliced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (port_width == 2'b00 || port_width == 2'b11)) |-> slice_idx == '0);

  assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && port_width == 2'b10) |-> rd_data[LW_W-1:LANE_W] == '0);

  assert_word_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && port_width == 2'b01) |-> rd_data[LW_W-1:2*LANE_W] == '0);

  assert_ready_withheld_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_en) |-> !lw_ready);

  assert_idle_read_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && rd_en) |=> slice_idx == '0);

  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_en && $stable(port_width)) |=> (rd_valid && $stable(rd_data)));
endmodule

bind bm_read_unpacker bm_unpack_checker #(
  .LW_W(LW_W), .LANE_W(LANE_W), .CNT_W(CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_width (port_width),
  .lw_ready   (lw_ready),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .slice_idx  (slice_idx),
  .order_q    (order_big_q)
);

// File: tb/bm_read_unpacker_tb_top.sv
`timescale 1ns/1ps
module bm_read_unpacker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        order_pin = 1'b1;
  logic [1:0]  port_width = 2'b10;
  logic        lw_valid = 1'b0;
  logic        lw_ready;
  logic [35:0] lw_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_valid;
  logic [35:0] rd_data;

  always #2.5 clk = ~clk;

  bm_read_unpacker dut_i (
    .clk(clk), .rst_n(rst_n), .order_pin(order_pin), .port_width(port_width),
    .lw_valid(lw_valid), .lw_ready(lw_ready), .lw_data(lw_data),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit cur_big = 1;
  string cur_req = "R3";
  int rd_mode = 2;          // 0 every cycle, 1 every other cycle, 2 stopped
  int cyc = 0;
  int first_rd = -1;
  int last_rd = -1;
  int n_reads = 0;
  logic [35:0] exp_q[$];

  task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit big);
    rst_n = 1'b0;
    order_pin = big;
    lw_valid = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(rd_valid == 1'b0, "R1", 36'(rd_valid), 36'd0);
    check(lw_ready == 1'b1, "R1", 36'(lw_ready), 36'd1);
    @(negedge clk);
    rst_n = 1'b1;
    cur_big = big;
    #1;
    check(rd_valid == 1'b0 && lw_ready == 1'b1, "R1", {34'd0, rd_valid, lw_ready}, 36'd1);
  endtask

  task automatic expect_word(logic [35:0] d);
    if (port_width == 2'b10) begin
      for (int s = 0; s < 4; s++) begin
        int ln = cur_big ? 3 - s : s;
        exp_q.push_back({27'd0, d[ln*9 +: 9]});
      end
    end else if (port_width == 2'b01) begin
      for (int s = 0; s < 2; s++) begin
        int pr = cur_big ? 1 - s : s;
        exp_q.push_back({18'd0, d[pr*18 +: 18]});
      end
    end else begin
      exp_q.push_back(d);
    end
  endtask

  // called just after a falling edge; returns just after a falling edge
  task automatic push_word(logic [35:0] d);
    bit acc;
    expect_word(d);
    lw_valid = 1'b1;
    lw_data = d;
    do begin
      #1;
      acc = lw_ready;
      @(negedge clk);
    end while (!acc);
    lw_valid = 1'b0;
  endtask

  task automatic drain(string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, req, 36'(exp_q.size()), 36'd0);
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor and read-strobe driver
  initial begin
    logic        pv = 1'b0;
    logic        pe = 1'b0;
    logic [35:0] pd = '0;
    forever begin
      @(negedge clk);
      case (rd_mode)
        0: rd_en = 1'b1;
        1: rd_en = cyc[0];
        default: rd_en = 1'b0;
      endcase
      cyc++;
      #1;
      if (rst_n && pv && !pe && rd_valid)           // R10: stall keeps data
        check(rd_data == pd, "R10", rd_data, pd);
      if (rst_n && rd_en && rd_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, rd_data, 36'hx);
        end else begin
          logic [35:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, cur_req, rd_data, e);
        end
        if (first_rd < 0) first_rd = cyc;
        last_rd = cyc;
        n_reads++;
      end
      pv = rd_valid;
      pe = rd_en;
      pd = rd_data;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // ---------- big-endian ----------
    @(negedge clk);
    do_reset(1'b1);
    order_pin = 1'b0;                         // R2: late change ignored
    port_width = 2'b10;
    rd_mode = 0;
    cur_req = "R3";
    push_word(36'h123456789);
    push_word(36'hABCDEF012);
    cur_req = "R2";
    push_word(36'hFEDCBA987);
    drain("R3");

    cur_req = "R5";
    port_width = 2'b01;
    rd_mode = 1;
    push_word(36'h89ABCDEF1);
    push_word(36'h0F0F13579);
    drain("R5");

    cur_req = "R6";
    port_width = 2'b00;
    rd_mode = 0;
    push_word(36'hC0FFEE123);
    port_width = 2'b00;
    push_word(36'h5A5A5A5A5);
    drain("R6");
    port_width = 2'b11;
    push_word(36'h3141592AB);
    drain("R6");

    // R8 and R9: stopped port
    port_width = 2'b10;
    cur_req = "R8";
    rd_mode = 0;
    repeat (3) @(negedge clk);                // R9: strobes on empty port
    rd_mode = 2;
    @(negedge clk);
    push_word(36'h2468ACE13);
    #1;
    check(rd_valid == 1'b1, "R9", 36'(rd_valid), 36'd1);
    check(rd_data == exp_q[0], "R9", rd_data, exp_q[0]);
    lw_valid = 1'b1;
    lw_data = 36'h777777777;
    repeat (3) begin
      #1;
      check(lw_ready == 1'b0, "R8", 36'(lw_ready), 36'd0);
      @(negedge clk);
    end
    lw_valid = 1'b0;
    rd_mode = 1;
    push_word(36'h777777777);
    drain("R8");

    // ---------- little-endian ----------
    rd_mode = 2;
    do_reset(1'b0);
    order_pin = 1'b1;
    port_width = 2'b10;
    rd_mode = 0;
    cur_req = "R4";
    push_word(36'h123456789);
    push_word(36'h987654321);
    drain("R4");

    cur_req = "R5";
    port_width = 2'b01;
    push_word(36'hABCDE1234);
    drain("R5");

    cur_req = "R6";
    port_width = 2'b00;
    push_word(36'hC0FFEE123);
    drain("R6");

    // R11: no gap between long words when reading every cycle
    cur_req = "R11";
    port_width = 2'b10;
    rd_mode = 2;
    @(negedge clk);
    push_word(36'h111222333);
    first_rd = -1;
    n_reads = 0;
    rd_mode = 0;
    push_word(36'h444555666);
    push_word(36'h777888999);
    drain("R11");
    check(n_reads == 12, "R11", 36'(n_reads), 36'd12);
    check(last_rd - first_rd == 11, "R11", 36'(last_rd - first_rd), 36'd11);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule